// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, one request at a time, whether a memory access may proceed. A requester presents a 32-bit address, an access kind (data read, data write or instruction fetch) and a privilege flag. The block compares the address against a parameterised set of protection regions (eight by default). It answers with an allow/deny verdict, a fault code, the read/write/execute permission set that applied and the index of the region that matched. Addresses pass through unchanged, so the block never produces a translated address.

Each region has two 32-bit words, written through a simple write port. The first word holds the start of the region, two access-permission bits and an execute-never bit. The second word holds the inclusive end of the region and an enable bit. Regions are aligned to 32 bytes and may have any size. A request that lands in more than one enabled region is a fault, not a priority decision. Three conditions bypass the region search and apply a fixed default map instead: the unit is switched off, the address is in the fixed peripheral window, or the background map is on and the requester is privileged.

The lookup is combinational. A two-state response machine (`ST_IDLE`, `ST_RESP`) registers the verdict one cycle after the request strobe. Its transitions are: `IDLE->RESP` on a strobe, `RESP->RESP` on a back-to-back strobe, and `RESP->IDLE` when no strobe arrives.

Top module: `mpu_region_checker`

## Requirements
- R1: A region covers the addresses from {word0[31:5], 5'b00000} up to and including {word1[31:5], 5'b11111}. The low five bits of either word play no part in the address compare.
- R2: Bit 0 of word1 enables the region, and a disabled region never matches. After reset every region word is zero, so every region is disabled.
- R3: If two or more enabled regions contain the address, and no bypass applies, the access is denied with fault code 0x00D, an empty permission set and rsp_region_vld low.
- R4: If the unit is enabled, no bypass applies and no enabled region contains the address, the access is denied with fault code 0x000 and an empty permission set.
- R5: With ctl_enable low, every access uses the default map and no region is reported.
- R6: Addresses 0xE0000000 to 0xE00FFFFF always use the default map, whatever the regions hold.
- R7: With ctl_bg_en high, a privileged request (req_priv=1) uses the default map. An unprivileged request ignores ctl_bg_en.
- R8: The default map grants read and write to every requester. It grants execute except in the system space 0xE0000000 to 0xFFFFFFFF.
- R9: For a single matched region, the permission field is word0[2:1]. When bit 2 is set, the region is read-only. When bit 1 is set, unprivileged access is allowed. Privileged requests always get read, and get write unless bit 2 is set. Unprivileged requests with bit 1 clear get nothing.
- R10: Execute is granted only when read or write is granted, execute-never (word0[0]) is clear and the address is outside the system space.
- R11: req_type encodes 0 = read, 1 = write, 2 = fetch, 3 = reserved (always denied). rsp_allow is the granted permission bit for the type. A denied access, other than the R4 case, reports 0x00D, and an allowed access reports 0x000.
- R12: rsp_valid and the results appear on the clock edge after the request strobe, and rsp_valid drops after a cycle with no strobe. cfg_sel=0 writes word0 and cfg_sel=1 writes word1. A write takes effect for the next request and is not seen by a request in the same cycle.
- R13: On a single region match, rsp_region_vld is high and rsp_region gives the index of the matched region. Otherwise rsp_region_vld is low and rsp_region is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Region word write strobe |
| cfg_sel | input | 1 | 0 = word0 (start and attributes), 1 = word1 (end and enable) |
| cfg_idx | input | IDX_W | Region index to write |
| cfg_wdata | input | 32 | Write data |
| ctl_enable | input | 1 | Global enable of the region search |
| ctl_bg_en | input | 1 | Default map for privileged requests |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_type | input | 2 | Access type |
| req_priv | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | Response valid |
| rsp_allow | output | 1 | Access allowed |
| rsp_fault | output | 12 | Fault code |
| rsp_perm | output | 3 | Granted {execute, write, read} |
| rsp_region_vld | output | 1 | A single region matched |
| rsp_region | output | IDX_W | Index of the matched region |

## Verification
The hardest case to reach from the ports is an overlap fault that one of the bypass paths should hide. A multi-match fault only appears when no bypass is active. The same overlapping pair must therefore give a clean default-map answer under global disable, under a privileged request with the background map on, and inside the peripheral window. The stimulus programs two regions that share a 32-byte granule. It then sweeps the addresses at and around that overlap, every access type, both privilege levels and every combination of ctl_enable and ctl_bg_en. A bench model derived from the requirements computes the expected answer for every case. A configuration write landing in the same cycle as a request is also driven, to show that the request sees the old region contents.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam int ADDR_W  = 32;
    localparam int FAULT_W = 12;
    localparam int GRAN_W  = 5;
    localparam int HI_W    = ADDR_W - GRAN_W;

    localparam logic [FAULT_W-1:0] FLT_OK         = 12'h000;
    localparam logic [FAULT_W-1:0] FLT_BACKGROUND = 12'h000;
    localparam logic [FAULT_W-1:0] FLT_PERMISSION = 12'h00D;

    localparam logic [11:0] PERIPH_TOP = 12'hE00;
    localparam logic [2:0]  SYS_TOP    = 3'b111;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        PATH_DEFAULT = 2'd0,
        PATH_REGION  = 2'd1,
        PATH_MULTI   = 2'd2,
        PATH_MISS    = 2'd3
    } path_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic [HI_W-1:0] lo_hi;
        logic [1:0]      ap;
        logic            xn;
        logic [HI_W-1:0] hi_hi;
        logic            en;
    } region_t;

    function automatic logic in_periph(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:ADDR_W-12] == PERIPH_TOP;
    endfunction

    function automatic logic in_system(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:ADDR_W-3] == SYS_TOP;
    endfunction

endpackage

// File: rtl/mpu_region_file.sv
module mpu_region_file
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_sel,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output region_t             regions [NUM_REGIONS]
);

    logic [3:0] unused_wbits;
    assign unused_wbits = cfg_wdata[4:1];

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
        logic sel_here;
        assign sel_here = cfg_we && (cfg_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regions[g] <= '0;
            end else if (sel_here) begin
                if (!cfg_sel) begin
                    regions[g].lo_hi <= cfg_wdata[ADDR_W-1:GRAN_W];
                    regions[g].ap    <= cfg_wdata[2:1];
                    regions[g].xn    <= cfg_wdata[0];
                end else begin
                    regions[g].hi_hi <= cfg_wdata[ADDR_W-1:GRAN_W];
                    regions[g].en    <= cfg_wdata[0];
                end
            end
        end
    end

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input  logic [ADDR_W-1:0]      addr,
    input  region_t                regions [NUM_REGIONS],
    output logic                   any_hit,
    output logic                   multi_hit,
    output logic [IDX_W-1:0]       hit_idx
);

    localparam int CNT_W = $clog2(NUM_REGIONS + 1);

    logic [NUM_REGIONS-1:0] hit_vec;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        logic [ADDR_W-1:0] lo_addr;
        logic [ADDR_W-1:0] hi_addr;
        assign lo_addr    = {regions[g].lo_hi, {GRAN_W{1'b0}}};
        assign hi_addr    = {regions[g].hi_hi, {GRAN_W{1'b1}}};
        assign hit_vec[g] = regions[g].en && (addr >= lo_addr) && (addr <= hi_addr);
    end

    logic [CNT_W-1:0] hit_cnt;

    always_comb begin
        hit_cnt = '0;
        hit_idx = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit_vec[i]) begin
                hit_cnt = hit_cnt + CNT_W'(1);
                hit_idx = IDX_W'(i);
            end
        end
        any_hit   = (hit_cnt != '0);
        multi_hit = (hit_cnt > CNT_W'(1));
    end

endmodule

// File: rtl/mpu_access_decide.sv
module mpu_access_decide
    import mpu_pkg::*;
(
    input  logic                ctl_enable,
    input  logic                ctl_bg_en,
    input  logic                priv,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          acc,
    input  logic                any_hit,
    input  logic                multi_hit,
    input  logic [1:0]          ap,
    input  logic                xn,
    output perm_t               perm,
    output logic                allow,
    output logic [FAULT_W-1:0]  fault,
    output logic                region_vld
);

    path_e path;
    logic  sys_space;
    logic  bypass;

    assign sys_space = in_system(addr);
    assign bypass    = !ctl_enable || in_periph(addr) || (ctl_bg_en && priv);

    always_comb begin
        if (bypass)         path = PATH_DEFAULT;
        else if (multi_hit) path = PATH_MULTI;
        else if (any_hit)   path = PATH_REGION;
        else                path = PATH_MISS;
    end

    always_comb begin
        perm       = '0;
        region_vld = 1'b0;
        unique case (path)
            PATH_DEFAULT: begin
                perm.r = 1'b1;
                perm.w = 1'b1;
                perm.x = !sys_space;
            end
            PATH_REGION: begin
                region_vld = 1'b1;
                perm.r     = priv || ap[0];
                perm.w     = (priv || ap[0]) && !ap[1];
                perm.x     = (perm.r || perm.w) && !xn && !sys_space;
            end
            PATH_MULTI: perm = '0;
            PATH_MISS:  perm = '0;
        endcase
    end

    always_comb begin
        unique case (acc_e'(acc))
            ACC_READ:  allow = perm.r;
            ACC_WRITE: allow = perm.w;
            ACC_FETCH: allow = perm.x;
            ACC_RSVD:  allow = 1'b0;
        endcase
        if (allow)                  fault = FLT_OK;
        else if (path == PATH_MISS) fault = FLT_BACKGROUND;
        else                        fault = FLT_PERMISSION;
    end

endmodule

// File: rtl/mpu_region_checker.sv
module mpu_region_checker
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [31:0]          cfg_wdata,
    input  logic                 ctl_enable,
    input  logic                 ctl_bg_en,
    input  logic                 req_valid,
    input  logic [31:0]          req_addr,
    input  logic [1:0]           req_type,
    input  logic                 req_priv,
    output logic                 rsp_valid,
    output logic                 rsp_allow,
    output logic [11:0]          rsp_fault,
    output logic [2:0]           rsp_perm,
    output logic                 rsp_region_vld,
    output logic [IDX_W-1:0]     rsp_region
);

    region_t          regions [NUM_REGIONS];
    logic             any_hit;
    logic             multi_hit;
    logic [IDX_W-1:0] hit_idx;
    region_t          sel_region;
    perm_t            perm_c;
    logic             allow_c;
    logic [11:0]      fault_c;
    logic             region_vld_c;

    mpu_region_file #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .regions   (regions)
    );

    mpu_region_match #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_match (
        .addr      (req_addr),
        .regions   (regions),
        .any_hit   (any_hit),
        .multi_hit (multi_hit),
        .hit_idx   (hit_idx)
    );

    assign sel_region = regions[hit_idx];

    mpu_access_decide u_decide (
        .ctl_enable (ctl_enable),
        .ctl_bg_en  (ctl_bg_en),
        .priv       (req_priv),
        .addr       (req_addr),
        .acc        (req_type),
        .any_hit    (any_hit),
        .multi_hit  (multi_hit),
        .ap         (sel_region.ap),
        .xn         (sel_region.xn),
        .perm       (perm_c),
        .allow      (allow_c),
        .fault      (fault_c),
        .region_vld (region_vld_c)
    );

    rsp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;
            ST_RESP: if (!req_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_allow      <= 1'b0;
            rsp_fault      <= '0;
            rsp_perm       <= '0;
            rsp_region_vld <= 1'b0;
            rsp_region     <= '0;
        end else if (req_valid) begin
            rsp_allow      <= allow_c;
            rsp_fault      <= fault_c;
            rsp_perm       <= perm_c;
            rsp_region_vld <= region_vld_c;
            rsp_region     <= region_vld_c ? hit_idx : '0;
        end else begin
            rsp_allow      <= 1'b0;
            rsp_fault      <= '0;
            rsp_perm       <= '0;
            rsp_region_vld <= 1'b0;
            rsp_region     <= '0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/mpu_region_checker_sva.sv
module mpu_region_checker_sva #(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_enable,
    input logic              req_valid,
    input logic [31:0]       req_addr,
    input logic [1:0]        req_type,
    input logic              rsp_valid,
    input logic              rsp_allow,
    input logic [11:0]       rsp_fault,
    input logic [2:0]        rsp_perm,
    input logic              rsp_region_vld,
    input logic [IDX_W-1:0]  rsp_region
);

    // R12
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R12
    rsp_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R11
    allow_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_allow) |-> (rsp_fault == 12'h000));

    // R10
    exec_needs_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_perm[2] |-> (rsp_perm[1:0] != 2'b00));

    // R10
    sys_no_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[31:29] == 3'b111) |=> !rsp_perm[2]);

    // R5
    disabled_read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ctl_enable && req_type == 2'd0) |=> rsp_allow);

    // R11
    rsvd_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type == 2'd3) |=> !rsp_allow);

    // R13
    region_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_region_vld |-> (rsp_region == '0));

endmodule

bind mpu_region_checker mpu_region_checker_sva #(.NUM_REGIONS(NUM_REGIONS)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_enable     (ctl_enable),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_type       (req_type),
    .rsp_valid      (rsp_valid),
    .rsp_allow      (rsp_allow),
    .rsp_fault      (rsp_fault),
    .rsp_perm       (rsp_perm),
    .rsp_region_vld (rsp_region_vld),
    .rsp_region     (rsp_region)
);

// File: tb/tb_mpu_region_checker.sv
`timescale 1ns/1ps
module tb_mpu_region_checker;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          ctl_enable = 1'b1;
    logic          ctl_bg_en = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_addr = '0;
    logic [1:0]    req_type = '0;
    logic          req_priv = 1'b0;
    logic          rsp_valid, rsp_allow, rsp_region_vld;
    logic [11:0]   rsp_fault;
    logic [2:0]    rsp_perm;
    logic [IW-1:0] rsp_region;

    int checks = 0;
    int fails  = 0;

    logic [31:0] sh_w0 [N];
    logic [31:0] sh_w1 [N];

    always #4 clk = ~clk;

    mpu_region_checker #(.NUM_REGIONS(N)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .ctl_enable(ctl_enable),
        .ctl_bg_en(ctl_bg_en), .req_valid(req_valid), .req_addr(req_addr),
        .req_type(req_type), .req_priv(req_priv), .rsp_valid(rsp_valid),
        .rsp_allow(rsp_allow), .rsp_fault(rsp_fault), .rsp_perm(rsp_perm),
        .rsp_region_vld(rsp_region_vld), .rsp_region(rsp_region)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        finish_run();
    end

    // Expected answer computed from R1-style rules, written independently.
    task automatic model(input logic [31:0] a, input logic [1:0] t, input logic p,
                         output logic [2:0] e_perm, output logic e_allow,
                         output logic [11:0] e_flt, output logic e_rv,
                         output logic [IW-1:0] e_idx);
        logic sys, per, r, w, x, miss;
        int cnt, who;
        sys = (a >= 32'hE000_0000);
        per = (a >= 32'hE000_0000) && (a <= 32'hE00F_FFFF);
        e_rv = 1'b0; e_idx = '0; miss = 1'b0;
        r = 1'b0; w = 1'b0; x = 1'b0;
        if (!ctl_enable || per || (ctl_bg_en && p)) begin
            r = 1'b1; w = 1'b1; x = !sys;
        end else begin
            cnt = 0; who = 0;
            for (int i = 0; i < N; i++) begin
                if (sh_w1[i][0] && a >= {sh_w0[i][31:5], 5'd0} && a <= {sh_w1[i][31:5], 5'h1F}) begin
                    cnt++; who = i;
                end
            end
            if (cnt == 0) miss = 1'b1;
            else if (cnt == 1) begin
                r = p | sh_w0[who][1];
                w = r & ~sh_w0[who][2];
                x = (r | w) & ~sh_w0[who][0] & ~sys;
                e_rv = 1'b1; e_idx = IW'(who);
            end
        end
        e_perm = {x, w, r};
        case (t)
            2'd0: e_allow = r;
            2'd1: e_allow = w;
            2'd2: e_allow = x;
            default: e_allow = 1'b0;
        endcase
        e_flt = (e_allow || miss) ? 12'h000 : 12'h00D;
    endtask

    task automatic compare(input string tag, input logic [2:0] e_perm, input logic e_allow,
                           input logic [11:0] e_flt, input logic e_rv, input logic [IW-1:0] e_idx);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_perm !== e_perm || rsp_allow !== e_allow ||
            rsp_fault !== e_flt || rsp_region_vld !== e_rv || rsp_region !== e_idx) begin
            fails++;
            $display("FAIL %s addr=%h type=%0d priv=%0d: actual v=%b perm=%b allow=%b flt=%h rv=%b idx=%0d expected v=1 perm=%b allow=%b flt=%h rv=%b idx=%0d",
                     tag, req_addr, req_type, req_priv, rsp_valid, rsp_perm, rsp_allow, rsp_fault,
                     rsp_region_vld, rsp_region, e_perm, e_allow, e_flt, e_rv, e_idx);
        end
    endtask

    task automatic wr(input int idx, input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = IW'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) sh_w1[idx] = d; else sh_w0[idx] = d;
    endtask

    task automatic issue(input string tag, input logic [31:0] a, input logic [1:0] t, input logic p);
        logic [2:0] ep; logic ea, erv; logic [11:0] ef; logic [IW-1:0] ei;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_type = t; req_priv = p;
        model(a, t, p, ep, ea, ef, erv, ei);
        @(negedge clk);
        req_valid = 1'b0;
        compare(tag, ep, ea, ef, erv, ei);
    endtask

    task automatic sweep(input string tag, input logic [31:0] a);
        for (int p = 0; p < 2; p++)
            for (int t = 0; t < 4; t++)
                issue(tag, a, 2'(t), p[0]);
    endtask

    initial begin
        logic [31:0] pts [6];
        for (int i = 0; i < N; i++) begin sh_w0[i] = '0; sh_w1[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_region_vld !== 1'b0) begin
            fails++;
            $display("FAIL R12 reset: actual v=%b allow=%b rv=%b expected 0 0 0", rsp_valid, rsp_allow, rsp_region_vld);
        end
        // R2 / R4: all regions disabled after reset, background fault
        sweep("R2_R4_reset_miss", 32'h0000_1000);

        // R9 / R10 / R1: every attribute combination on region 0, boundary sweep
        pts[0] = 32'h0000_0FFF; pts[1] = 32'h0000_1000; pts[2] = 32'h0000_101F;
        pts[3] = 32'h0000_1FFF; pts[4] = 32'h0000_2000; pts[5] = 32'h0000_1800;
        wr(0, 1'b1, 32'h0000_1FE0 | 32'h1E);  // enable bit clear, low bits junk
        sweep("R2_disabled", 32'h0000_1800);
        wr(0, 1'b1, 32'h0000_1FE1 | 32'h1E);
        for (int attr = 0; attr < 8; attr++) begin
            wr(0, 1'b0, 32'h0000_1018 | 32'(attr));
            for (int k = 0; k < 6; k++) sweep("R1_R9_R10_R11_R13", pts[k]);
        end

        // R13: a second region at another index
        wr(5, 1'b0, 32'h0004_0003);
        wr(5, 1'b1, 32'h0004_00E1);
        sweep("R13_idx5", 32'h0004_00FF);
        sweep("R1_R4_past_limit", 32'h0004_0100);

        // R3: overlap of region 5 with region 2 on one granule
        wr(2, 1'b0, 32'h0004_00E6);
        wr(2, 1'b1, 32'h0004_0201);
        for (int en = 0; en < 2; en++)
            for (int bg = 0; bg < 2; bg++) begin
                ctl_enable = en[0]; ctl_bg_en = bg[0];
                sweep("R3_R5_R7_overlap", 32'h0004_00E0);
                sweep("R3_R5_R7_overlap", 32'h0004_00FF);
                sweep("R13_R7_idx2", 32'h0004_0100);
                sweep("R4_R5_R7_miss", 32'h0800_0000);
            end
        ctl_enable = 1'b1; ctl_bg_en = 1'b0;

        // R6 / R8 / R10: peripheral window and system space against a region
        wr(3, 1'b0, 32'hE000_0000);          // xn clear, AP=0
        wr(3, 1'b1, 32'hFFFF_FFE1);
        sweep("R6_R8_periph_lo", 32'hE000_0000);
        sweep("R6_R8_periph_hi", 32'hE00F_FFFF);
        sweep("R10_sys_region", 32'hE010_0000);
        sweep("R10_sys_top", 32'hFFFF_FFFF);
        ctl_enable = 1'b0;
        sweep("R5_R8_sys_default", 32'hF000_0000);
        sweep("R5_R8_low_default", 32'h0000_0000);
        ctl_enable = 1'b1;

        // R12: write in same cycle as a request is not seen by it
        begin
            logic [2:0] ep; logic ea, erv; logic [11:0] ef; logic [IW-1:0] ei;
            @(negedge clk);
            req_valid = 1'b1; req_addr = 32'h0010_0000; req_type = 2'd0; req_priv = 1'b1;
            cfg_we = 1'b1; cfg_sel = 1'b1; cfg_idx = 3'd6; cfg_wdata = 32'h0010_0001;
            model(req_addr, req_type, req_priv, ep, ea, ef, erv, ei);
            @(negedge clk);
            req_valid = 1'b0; cfg_we = 1'b0;
            compare("R12_same_cycle_old", ep, ea, ef, erv, ei);
            sh_w1[6] = 32'h0010_0001;
            @(negedge clk);
            checks++;
            if (rsp_valid !== 1'b0) begin
                fails++;
                $display("FAIL R12 idle: actual rsp_valid=%b expected 0", rsp_valid);
            end
            issue("R12_after_write", 32'h0010_0000, 2'd0, 1'b1);
        end

        // R12: back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_1800; req_type = 2'd0; req_priv = 1'b1;
        @(negedge clk);
        begin
            logic [2:0] ep; logic ea, erv; logic [11:0] ef; logic [IW-1:0] ei;
            model(32'h0000_1800, 2'd0, 1'b1, ep, ea, ef, erv, ei);
            compare("R12_b2b_first", ep, ea, ef, erv, ei);
            req_addr = 32'h0800_0000;
            model(32'h0800_0000, 2'd0, 1'b1, ep, ea, ef, erv, ei);
            @(negedge clk);
            req_valid = 1'b0;
            compare("R12_b2b_second", ep, ea, ef, erv, ei);
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule